// File: doc/BRIEF.md
# Low-Power Stop Mode Sequencer

This controller decides when a microcontroller goes into one of its two stop states and when it comes back out. The CPU raises a one-cycle stop request. The sequencer honours it only when the CPU's stop-disable flag is clear. Stop entry is held off while the coprocessor is busy, while its forced-activity bit is set, or while a non-volatile memory command is running. During that deferral the clocks keep running. An unmasked interrupt that arrives in the window cancels the stop, and the CPU carries on.

A select bit picks the stop state at the moment of entry. Pseudo stop keeps the oscillator running. Full stop turns the oscillator off. Leaving full stop normally includes a programmable oscillator settling wait. A fast-wake option skips that wait and resumes at once. A coprocessor request wakes only the coprocessor side of the chip. When that work ends with no CPU interrupt and no forced activity, the sequencer drops back into the same stop state without the CPU noticing. A single-cycle pulse tells the CPU each time it is to resume.

Top module: `stop_sequencer`

## Requirements
- R1: A stop request while stopDisable is 1 is ignored: the state stays run (code 0) and all enables stay 1.
- R2: A stop request while copBusy, copForce or nvmBusy is 1 moves to the deferral state (code 1) with sysClkEn, oscEn and periphEn still 1. The stop state is entered on the first clock edge at which all three are 0.
- R3: An unmasked interrupt in the deferral state returns to run (code 0) on the next edge and pulses wakePulse.
- R4: With pseudoSel 1 at entry, the state becomes pseudo stop (code 2) with sysClkEn 0, oscEn 1 and periphEn 0.
- R5: With pseudoSel 0 at entry, the state becomes full stop (code 3) with sysClkEn, oscEn and periphEn all 0.
- R6: Stop is left on extIrqA, on extIrqB, or on any set bit of intPend.
- R7: An interrupt in pseudo stop gives run on the next edge, with wakePulse high in that cycle.
- R8: An interrupt in full stop with fastWake 0 enters the oscillator wait (code 4) for oscDelay+1 cycles, with oscEn 1 and sysClkEn 0, and then enters run.
- R9: An interrupt in full stop with fastWake 1 gives run on the next edge.
- R10: copWakeReq in a stop state leads to coprocessor-only run (code 5) with sysClkEn 1, periphEn 0 and no wakePulse. Full stop without fastWake passes through the oscillator wait first. Once copBusy and copWakeReq are both 0, the sequencer returns to the stop state it left.
- R11: In coprocessor-only run, an interrupt or copForce sends the sequencer to run with wakePulse instead of back to stop.
- R12: wakePulse is high for exactly one cycle, only on entry to run from a stop, deferral or wait state that the CPU resumes from.
- R13: rstN low forces run, all enables 1 and wakePulse 0 at once, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | One-cycle CPU stop request |
| stopDisable | input | 1 | CPU stop-disable flag |
| copBusy | input | 1 | Coprocessor running a thread |
| copForce | input | 1 | Coprocessor forced-activity bit |
| nvmBusy | input | 1 | Non-volatile memory command in progress |
| pseudoSel | input | 1 | 1 selects pseudo stop, 0 full stop |
| fastWake | input | 1 | Skip the oscillator wait when leaving full stop |
| extIrqA | input | 1 | External interrupt line A |
| extIrqB | input | 1 | External interrupt line B |
| intPend | input | IRQ_N | Masked, CPU-serviced interrupt pending vector |
| copWakeReq | input | 1 | Coprocessor-serviced wake request |
| oscDelay | input | DLY_W | Oscillator settling count |
| pwrState | output | 3 | Current state code |
| sysClkEn | output | 1 | System clock enable |
| oscEn | output | 1 | Oscillator enable |
| periphEn | output | 1 | General peripheral domain enable |
| wakePulse | output | 1 | CPU resume pulse |

## Verification
The bench builds the block with DLY_W = 4 and IRQ_N = 4. The narrow counter lets the bench reach both the zero-length and the longer oscillator waits and count every cycle of them. The short pending vector keeps the interrupt rows of the vector table readable, while still covering a non-line interrupt source next to both external lines.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_DEFER   = 3'd1,
    ST_PSEUDO  = 3'd2,
    ST_FULL    = 3'd3,
    ST_OSCWAIT = 3'd4,
    ST_COPRUN  = 3'd5
  } pwrState_e;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic latchTgt;
    logic setCpu;
    logic clrCpu;
  } seqStrobe_t;

  typedef struct packed {
    logic cntZero;
    logic tgtPseudo;
    logic cpuFlag;
  } seqStat_t;
endpackage

// File: rtl/stop_seq_dp.sv
module stop_seq_dp
  import stop_seq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [DLY_W-1:0] oscDelay,
  input  logic             pseudoSel,
  output seqStat_t         stat
);
  logic [DLY_W-1:0] cnt;
  logic             tgtPseudo;
  logic             cpuFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      tgtPseudo <= 1'b0;
      cpuFlag   <= 1'b0;
    end else begin
      if (strb.loadCnt)      cnt <= oscDelay;
      else if (strb.decCnt)  cnt <= cnt - 1'b1;
      if (strb.latchTgt)     tgtPseudo <= pseudoSel;
      if (strb.setCpu)       cpuFlag <= 1'b1;
      else if (strb.clrCpu)  cpuFlag <= 1'b0;
    end
  end

  assign stat.cntZero   = (cnt == '0);
  assign stat.tgtPseudo = tgtPseudo;
  assign stat.cpuFlag   = cpuFlag;

  AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCnt |-> (cnt != '0)); // R8
endmodule

// File: rtl/stop_seq_ctrl.sv
module stop_seq_ctrl
  import stop_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       stopDisable,
  input  logic       copBusy,
  input  logic       copForce,
  input  logic       nvmBusy,
  input  logic       pseudoSel,
  input  logic       fastWake,
  input  logic       cpuWake,
  input  logic       copWakeReq,
  input  seqStat_t   stat,
  output seqStrobe_t strb,
  output pwrState_e  st,
  output logic       sysClkEn,
  output logic       oscEn,
  output logic       periphEn,
  output logic       wakePulse
);
  pwrState_e nxt;
  logic      wakeNxt;
  logic      busy;

  assign busy = copBusy | copForce | nvmBusy;

  always_comb begin
    nxt     = st;
    wakeNxt = 1'b0;
    strb    = '0;
    unique case (st)
      ST_RUN: begin
        if (stopReq && !stopDisable) begin
          if (busy) nxt = ST_DEFER;
          else begin
            nxt = pseudoSel ? ST_PSEUDO : ST_FULL;
            strb.latchTgt = 1'b1;
          end
        end
      end
      ST_DEFER: begin
        if (cpuWake) begin
          nxt = ST_RUN;
          wakeNxt = 1'b1;
        end else if (!busy) begin
          nxt = pseudoSel ? ST_PSEUDO : ST_FULL;
          strb.latchTgt = 1'b1;
        end
      end
      ST_PSEUDO: begin
        if (cpuWake) begin
          nxt = ST_RUN;
          wakeNxt = 1'b1;
        end else if (copWakeReq) nxt = ST_COPRUN;
      end
      ST_FULL: begin
        if (cpuWake) begin
          if (fastWake) begin
            nxt = ST_RUN;
            wakeNxt = 1'b1;
          end else begin
            nxt = ST_OSCWAIT;
            strb.loadCnt = 1'b1;
            strb.setCpu  = 1'b1;
          end
        end else if (copWakeReq) begin
          if (fastWake) nxt = ST_COPRUN;
          else begin
            nxt = ST_OSCWAIT;
            strb.loadCnt = 1'b1;
            strb.clrCpu  = 1'b1;
          end
        end
      end
      ST_OSCWAIT: begin
        if (stat.cntZero) begin
          if (stat.cpuFlag || cpuWake) begin
            nxt = ST_RUN;
            wakeNxt = 1'b1;
          end else nxt = ST_COPRUN;
        end else begin
          strb.decCnt = 1'b1;
          if (cpuWake) strb.setCpu = 1'b1;
        end
      end
      ST_COPRUN: begin
        if (cpuWake || copForce) begin
          nxt = ST_RUN;
          wakeNxt = 1'b1;
        end else if (!copBusy && !copWakeReq)
          nxt = stat.tgtPseudo ? ST_PSEUDO : ST_FULL;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_RUN;
      wakePulse <= 1'b0;
    end else begin
      st        <= nxt;
      wakePulse <= wakeNxt;
    end
  end

  assign sysClkEn = (st == ST_RUN) || (st == ST_DEFER) || (st == ST_COPRUN);
  assign oscEn    = (st != ST_FULL);
  assign periphEn = (st == ST_RUN) || (st == ST_DEFER);

  AST_STOP_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN && stopDisable) |=> (st == ST_RUN)); // R1
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_DEFER && busy && !cpuWake) |=> (st == ST_DEFER)); // R2
  AST_OSC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_OSCWAIT && !stat.cntZero) |=> (st == ST_OSCWAIT)); // R8
  AST_COP_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_COPRUN && !copBusy && !copWakeReq && !cpuWake && !copForce)
      |=> (st == ST_PSEUDO || st == ST_FULL)); // R10
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse); // R12
  AST_WAKE_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (st == ST_RUN)); // R12
endmodule

// File: rtl/stop_sequencer.sv
module stop_sequencer
  import stop_seq_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int IRQ_N = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopReq,
  input  logic             stopDisable,
  input  logic             copBusy,
  input  logic             copForce,
  input  logic             nvmBusy,
  input  logic             pseudoSel,
  input  logic             fastWake,
  input  logic             extIrqA,
  input  logic             extIrqB,
  input  logic [IRQ_N-1:0] intPend,
  input  logic             copWakeReq,
  input  logic [DLY_W-1:0] oscDelay,
  output logic [2:0]       pwrState,
  output logic             sysClkEn,
  output logic             oscEn,
  output logic             periphEn,
  output logic             wakePulse
);
  seqStrobe_t strb;
  seqStat_t   stat;
  pwrState_e  st;
  logic       cpuWake;

  assign cpuWake  = extIrqA | extIrqB | (|intPend);
  assign pwrState = st;

  stop_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .stopDisable(stopDisable),
    .copBusy(copBusy), .copForce(copForce), .nvmBusy(nvmBusy),
    .pseudoSel(pseudoSel), .fastWake(fastWake), .cpuWake(cpuWake),
    .copWakeReq(copWakeReq), .stat(stat), .strb(strb), .st(st),
    .sysClkEn(sysClkEn), .oscEn(oscEn), .periphEn(periphEn),
    .wakePulse(wakePulse)
  );

  stop_seq_dp #(.DLY_W(DLY_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .oscDelay(oscDelay),
    .pseudoSel(pseudoSel), .stat(stat)
  );
endmodule

// File: tb/test_stop_sequencer.sv
module test_stop_sequencer;
  localparam int DLY_W = 4;
  localparam int IRQ_N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 0, stopDisable = 0, copBusy = 0, copForce = 0, nvmBusy = 0;
  logic pseudoSel = 0, fastWake = 0, extIrqA = 0, extIrqB = 0, copWakeReq = 0;
  logic [IRQ_N-1:0] intPend = '0;
  logic [DLY_W-1:0] oscDelay = 4'd3;
  logic [2:0] pwrState;
  logic sysClkEn, oscEn, periphEn, wakePulse;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  stop_sequencer #(.DLY_W(DLY_W), .IRQ_N(IRQ_N)) i_stop_sequencer (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .stopDisable(stopDisable),
    .copBusy(copBusy), .copForce(copForce), .nvmBusy(nvmBusy),
    .pseudoSel(pseudoSel), .fastWake(fastWake), .extIrqA(extIrqA),
    .extIrqB(extIrqB), .intPend(intPend), .copWakeReq(copWakeReq),
    .oscDelay(oscDelay), .pwrState(pwrState), .sysClkEn(sysClkEn),
    .oscEn(oscEn), .periphEn(periphEn), .wakePulse(wakePulse)
  );

  // {stopReq,stopDis,copBusy,nvmBusy, pseudoSel,irqA,intP0,copWake, expState[2:0],expWake}
  localparam logic [11:0] VEC [18] = '{
    12'b1100_0000_0000, // R1 stop disabled
    12'b0000_0000_0000,
    12'b1000_1000_0100, // R4 pseudo entry
    12'b0000_0000_0100,
    12'b0000_0100_0001, // R6 R7 line A wake
    12'b0000_0000_0000, // R12 pulse gone
    12'b1001_0000_0010, // R2 defer on memory busy
    12'b0001_0000_0010,
    12'b0000_1000_0100, // R2 enter once idle
    12'b0000_0010_0001, // R6 pending vector wake
    12'b1010_0000_0010, // R2 defer on coprocessor
    12'b0010_0010_0001, // R3 abandon stop
    12'b0000_0000_0000,
    12'b1000_1000_0100,
    12'b0000_0001_1010, // R10 coprocessor wake
    12'b0010_0000_1010,
    12'b0000_0000_0100, // R10 silent return
    12'b0000_0100_0001
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn();
    stopReq = 0; stopDisable = 0; copBusy = 0; copForce = 0; nvmBusy = 0;
    pseudoSel = 0; fastWake = 0; extIrqA = 0; extIrqB = 0; copWakeReq = 0;
    intPend = '0;
  endtask

  task automatic enterFull();
    stopReq = 1; pseudoSel = 0;
    step();
    clearIn();
    check("R5 state", pwrState, 3);
    check("R5 enables", {sysClkEn, oscEn, periphEn}, 0);
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    check("R13 reset state", pwrState, 0);
    check("R13 reset enables", {sysClkEn, oscEn, periphEn, wakePulse}, 4'b1110);
    step(); step();
    rstN = 1;

    for (int i = 0; i < 18; i++) begin
      {stopReq, stopDisable, copBusy, nvmBusy, pseudoSel, extIrqA, copWakeReq} =
        {VEC[i][11:7], VEC[i][6], VEC[i][4]};
      intPend = {3'b000, VEC[i][5]};
      step();
      check($sformatf("R1-table row %0d state", i), pwrState, int'(VEC[i][3:1]));
      check($sformatf("R12 row %0d wake", i), wakePulse, int'(VEC[i][0]));
      if (pwrState == 3'd2) check("R4 enables", {sysClkEn, oscEn, periphEn}, 3'b010);
      if (pwrState == 3'd5) check("R10 enables", {sysClkEn, oscEn, periphEn}, 3'b110);
      clearIn();
    end

    // R8: full stop, line B, oscillator wait of oscDelay+1 cycles
    oscDelay = 4'd3;
    enterFull();
    extIrqB = 1;
    step();
    clearIn();
    begin
      int waitCnt = 0;
      while (pwrState == 3'd4 && waitCnt < 40) begin
        check("R8 wait enables", {sysClkEn, oscEn, periphEn}, 3'b010);
        waitCnt++;
        step();
      end
      check("R8 wait length", waitCnt, 4);
    end
    check("R8 run after wait", pwrState, 0);
    check("R6 R12 wake after wait", wakePulse, 1);

    // R8: zero delay gives a single wait cycle
    oscDelay = 4'd0;
    enterFull();
    intPend = 4'b1000;
    step();
    clearIn();
    check("R8 zero delay wait", pwrState, 4);
    step();
    check("R8 zero delay run", pwrState, 0);

    // R9: fast wake
    enterFull();
    fastWake = 1; extIrqA = 1;
    step();
    clearIn();
    check("R9 fast wake state", pwrState, 0);
    check("R9 fast wake pulse", wakePulse, 1);

    // R10 R12: coprocessor wake from full passes the wait, then returns to full
    oscDelay = 4'd2;
    enterFull();
    copWakeReq = 1; copBusy = 1;
    step();
    copWakeReq = 0;
    check("R10 wait first", pwrState, 4);
    step(); step(); step();
    check("R10 coprocessor run", pwrState, 5);
    check("R12 no pulse on coprocessor wake", wakePulse, 0);
    copBusy = 0;
    step();
    check("R10 back to full", pwrState, 3);

    // R11: forced activity sends the CPU back to run
    fastWake = 1; copWakeReq = 1; copBusy = 1;
    step();
    clearIn();
    copBusy = 1;
    check("R10 fast coprocessor run", pwrState, 5);
    copForce = 1;
    step();
    clearIn();
    check("R11 force to run", pwrState, 0);
    check("R11 pulse", wakePulse, 1);

    // R2: forced activity alone defers stop
    stopReq = 1; copForce = 1;
    step();
    stopReq = 0;
    check("R2 force defers", pwrState, 1);
    check("R2 clocks run", {sysClkEn, oscEn, periphEn}, 3'b111);
    copForce = 0; pseudoSel = 1;
    step();
    clearIn();
    check("R2 enter after force", pwrState, 2);

    // R13: reset out of pseudo stop acts at once
    rstN = 0;
    #1;
    check("R13 async reset state", pwrState, 0);
    check("R13 async reset enables", {sysClkEn, oscEn, periphEn, wakePulse}, 4'b1110);
    step();
    rstN = 1;
    step();
    check("R13 stays run", pwrState, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule